// File: doc/BRIEF.md
# Byte-move addressing sequencer

This block carries out the byte-move instructions of a small 8-bit processor core, one bus access per clock. It owns the accumulator A, the index registers X and Y, the stack pointer SP and the negative (N) and zero (Z) flags. A controller that has already fetched an opcode presents it with a one-cycle `start` strobe, together with the address of the first operand byte. The sequencer then walks through operand fetches, pointer reads, idle cycles and data accesses until the move is complete.

The bus is a plain synchronous port. Read data is returned combinationally in the same cycle as the read strobe. The address space is 16 bits wide, and the zero page (0x0000 to 0x00FF) serves as the direct page. Stores always read their target one cycle before writing it, and every index addition costs one idle cycle. The visible bus trace is therefore longer than the minimum a load/store unit would need. When a move finishes, `done` pulses for one cycle. The register file, the flags and the advanced operand pointer can then be read on the outputs.

Top module: `movseq`

## Requirements
- R1: Register transfers take one idle bus cycle (no strobe): 0x7D X→A, 0xDD Y→A, 0x5D A→X, 0xFD A→Y, 0x9D SP→X, 0xBD X→SP. The transfer 0xBD leaves N and Z unchanged.
- R2: Every value written into A, X or Y sets N to bit 7 of the value and sets Z exactly when the value is 0x00. Stores change no register and no flag, apart from the X post-increment of R8.
- R3: Immediate loads 0xE8 (A), 0xCD (X) and 0x8D (Y) make one read at the operand address. `next_pc` advances by one for each operand byte read.
- R4: Direct-page forms use address {0x00, d}. Loads 0xE4/0xF8/0xEB read that address after the operand. Stores 0xC4 (A), 0xD8 (X) and 0xCB (Y) read it and then write it in the next cycle.
- R5: Indexed forms spend one idle cycle after their operand bytes. These are dp+X (0xF4 A, 0xFB Y, 0xD4 A, 0xDB Y), dp+Y (0xF9 X, 0xD9 X), abs+X (0xF5, 0xD5) and abs+Y (0xF6, 0xD6). Direct-page sums wrap within 8 bits, and absolute sums carry into the high byte.
- R6: Absolute forms read the low address byte and then the high byte. These are loads 0xE5/0xE9/0xEC and stores 0xC5/0xC9/0xCC for A/X/Y.
- R7: 0xE7 and 0xC7 take their pointer from p=d+X; 0xF7 and 0xD7 take it from p=d. The pointer's low byte is read at {0x00,p} and its high byte at {0x00,p+1}, with 8-bit wrap. 0xE7/0xC7 then access the pointer itself, and 0xF7/0xD7 access pointer+Y. The store 0xD7 places its idle cycle after the pointer reads.
- R8: 0xE6 loads A from {0x00,X} after one idle cycle, and 0xC6 reads and then writes A there. 0xBF loads A from {0x00,X} and then idles. 0xAF idles twice and then writes A there. Both 0xBF and 0xAF then increment X modulo 256 without touching the flags.
- R9: 0xFA reads a source operand, reads the source byte, reads a destination operand and writes the byte. 0x8F reads an immediate byte and a direct-page operand, reads that address and then writes the immediate there.
- R10: `busy` is high from the cycle after an accepted `start` through the last bus cycle. `done` is high for exactly the following cycle. A `start` while `busy` is high is ignored.
- R11: Any other opcode spends one idle cycle and changes no register, flag or `next_pc`.
- R12: After reset, A, X, Y, SP, N, Z, `next_pc`, `busy`, `done` and both strobes are zero.
- R13: No strobe is active while `busy` is low, and read and write are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the move given by `opcode` |
| opcode | input | 8 | Move opcode, sampled with `start` |
| op_pc | input | 16 | Address of the first operand byte, sampled with `start` |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Operand pointer, advanced past the bytes consumed |
| mem_addr | output | 16 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | X index |
| reg_y | output | 8 | Y index |
| reg_sp | output | 8 | Stack pointer |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Two functions can fall on the same edge. One is the completion of one move. The other is the arrival of a new `start` while the sequencer is still busy, which must not disturb the running sequence or launch a second one. The bench raises `start` with a different opcode in the second cycle of a long indirect store. It then judges the whole bus trace, the single `done` pulse and the register file against an independent model. A second coincidence is the post-increment of X on the same edge as the final access of 0xBF/0xAF. It is judged with X at 0xFF: the access must use 0x00FF and X must come back as 0x00 with the flags held.

// File: rtl/movseq.sv
module movseq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] op_pc,
  output logic        busy,
  output logic        done,
  output logic [15:0] next_pc,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  reg_a,
  output logic [7:0]  reg_x,
  output logic [7:0]  reg_y,
  output logic [7:0]  reg_sp,
  output logic        flag_n,
  output logic        flag_z
);
  localparam logic [3:0] C_XFER = 4'd0, C_IMM = 4'd1, C_DP = 4'd2, C_DPI = 4'd3,
                         C_ABS = 4'd4, C_ABSI = 4'd5, C_INDX = 4'd6, C_INDY = 4'd7,
                         C_XIND = 4'd8, C_XINC = 4'd9, C_DPDP = 4'd10, C_DPIMM = 4'd11,
                         C_BAD = 4'd12;
  localparam logic [3:0] K_IDLE = 4'd0, K_XFER = 4'd1, K_IMM = 4'd2, K_OPLO = 4'd3,
                         K_OPHI = 4'd4, K_OPTMP = 4'd5, K_SRC = 4'd6, K_PLO = 4'd7,
                         K_PHI = 4'd8, K_LOAD = 4'd9, K_DUMMY = 4'd10, K_STORE = 4'd11;
  localparam logic [1:0] R_A = 2'd0, R_X = 2'd1, R_Y = 2'd2, R_SP = 2'd3;

  logic        busy_q, done_q;
  logic [7:0]  op_q;
  logic [2:0]  step_q;
  logic [15:0] pc_q;
  logic [7:0]  lo_q, hi_q, plo_q, phi_q, tmp_q;
  logic [7:0]  a_q, x_q, y_q, sp_q;
  logic        n_q, z_q;

  logic [3:0]  cls;
  logic        st;
  logic [1:0]  rsel, ssel;
  logic        isel;

  always_comb begin
    cls = C_BAD; st = 1'b0; rsel = R_A; ssel = R_A; isel = 1'b0;
    case (op_q)
      8'h7D: begin cls = C_XFER; rsel = R_A;  ssel = R_X; end
      8'hDD: begin cls = C_XFER; rsel = R_A;  ssel = R_Y; end
      8'h5D: begin cls = C_XFER; rsel = R_X;  ssel = R_A; end
      8'hFD: begin cls = C_XFER; rsel = R_Y;  ssel = R_A; end
      8'h9D: begin cls = C_XFER; rsel = R_X;  ssel = R_SP; end
      8'hBD: begin cls = C_XFER; rsel = R_SP; ssel = R_X; end
      8'hE8: begin cls = C_IMM; rsel = R_A; end
      8'hCD: begin cls = C_IMM; rsel = R_X; end
      8'h8D: begin cls = C_IMM; rsel = R_Y; end
      8'hE4: begin cls = C_DP; rsel = R_A; end
      8'hF8: begin cls = C_DP; rsel = R_X; end
      8'hEB: begin cls = C_DP; rsel = R_Y; end
      8'hF4: begin cls = C_DPI; rsel = R_A; end
      8'hF9: begin cls = C_DPI; rsel = R_X; isel = 1'b1; end
      8'hFB: begin cls = C_DPI; rsel = R_Y; end
      8'hE5: begin cls = C_ABS; rsel = R_A; end
      8'hE9: begin cls = C_ABS; rsel = R_X; end
      8'hEC: begin cls = C_ABS; rsel = R_Y; end
      8'hF5: begin cls = C_ABSI; rsel = R_A; end
      8'hF6: begin cls = C_ABSI; rsel = R_A; isel = 1'b1; end
      8'hE7: begin cls = C_INDX; rsel = R_A; end
      8'hF7: begin cls = C_INDY; rsel = R_A; end
      8'hE6: begin cls = C_XIND; rsel = R_A; end
      8'hBF: begin cls = C_XINC; rsel = R_A; end
      8'hC4: begin cls = C_DP; st = 1'b1; rsel = R_A; end
      8'hD8: begin cls = C_DP; st = 1'b1; rsel = R_X; end
      8'hCB: begin cls = C_DP; st = 1'b1; rsel = R_Y; end
      8'hD4: begin cls = C_DPI; st = 1'b1; rsel = R_A; end
      8'hD9: begin cls = C_DPI; st = 1'b1; rsel = R_X; isel = 1'b1; end
      8'hDB: begin cls = C_DPI; st = 1'b1; rsel = R_Y; end
      8'hC5: begin cls = C_ABS; st = 1'b1; rsel = R_A; end
      8'hC9: begin cls = C_ABS; st = 1'b1; rsel = R_X; end
      8'hCC: begin cls = C_ABS; st = 1'b1; rsel = R_Y; end
      8'hD5: begin cls = C_ABSI; st = 1'b1; rsel = R_A; end
      8'hD6: begin cls = C_ABSI; st = 1'b1; rsel = R_A; isel = 1'b1; end
      8'hC7: begin cls = C_INDX; st = 1'b1; rsel = R_A; end
      8'hD7: begin cls = C_INDY; st = 1'b1; rsel = R_A; end
      8'hC6: begin cls = C_XIND; st = 1'b1; rsel = R_A; end
      8'hAF: begin cls = C_XINC; st = 1'b1; rsel = R_A; end
      8'hFA: begin cls = C_DPDP; st = 1'b1; end
      8'h8F: begin cls = C_DPIMM; st = 1'b1; end
      default: cls = C_BAD;
    endcase
  end

  function automatic logic [23:0] mk(input logic [3:0] k0, k1, k2, k3, k4, k5);
    return {k5, k4, k3, k2, k1, k0};
  endfunction

  logic [23:0] seq;
  logic [2:0]  len;

  always_comb begin
    seq = '0;
    len = 3'd1;
    case (cls)
      C_XFER: seq = mk(K_XFER, K_IDLE, K_IDLE, K_IDLE, K_IDLE, K_IDLE);
      C_IMM:  seq = mk(K_IMM, K_IDLE, K_IDLE, K_IDLE, K_IDLE, K_IDLE);
      C_DP: if (st) begin seq = mk(K_OPLO, K_DUMMY, K_STORE, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
            else    begin seq = mk(K_OPLO, K_LOAD, K_IDLE, K_IDLE, K_IDLE, K_IDLE); len = 3'd2; end
      C_DPI: if (st) begin seq = mk(K_OPLO, K_IDLE, K_DUMMY, K_STORE, K_IDLE, K_IDLE); len = 3'd4; end
             else    begin seq = mk(K_OPLO, K_IDLE, K_LOAD, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
      C_ABS: if (st) begin seq = mk(K_OPLO, K_OPHI, K_DUMMY, K_STORE, K_IDLE, K_IDLE); len = 3'd4; end
             else    begin seq = mk(K_OPLO, K_OPHI, K_LOAD, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
      C_ABSI: if (st) begin seq = mk(K_OPLO, K_OPHI, K_IDLE, K_DUMMY, K_STORE, K_IDLE); len = 3'd5; end
              else    begin seq = mk(K_OPLO, K_OPHI, K_IDLE, K_LOAD, K_IDLE, K_IDLE); len = 3'd4; end
      C_INDX: if (st) begin seq = mk(K_OPLO, K_IDLE, K_PLO, K_PHI, K_DUMMY, K_STORE); len = 3'd6; end
              else    begin seq = mk(K_OPLO, K_IDLE, K_PLO, K_PHI, K_LOAD, K_IDLE); len = 3'd5; end
      C_INDY: if (st) begin seq = mk(K_OPLO, K_PLO, K_PHI, K_IDLE, K_DUMMY, K_STORE); len = 3'd6; end
              else    begin seq = mk(K_OPLO, K_IDLE, K_PLO, K_PHI, K_LOAD, K_IDLE); len = 3'd5; end
      C_XIND: if (st) begin seq = mk(K_IDLE, K_DUMMY, K_STORE, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
              else    begin seq = mk(K_IDLE, K_LOAD, K_IDLE, K_IDLE, K_IDLE, K_IDLE); len = 3'd2; end
      C_XINC: if (st) begin seq = mk(K_IDLE, K_IDLE, K_STORE, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
              else    begin seq = mk(K_IDLE, K_LOAD, K_IDLE, K_IDLE, K_IDLE, K_IDLE); len = 3'd3; end
      C_DPDP:  begin seq = mk(K_OPLO, K_SRC, K_OPLO, K_STORE, K_IDLE, K_IDLE); len = 3'd4; end
      C_DPIMM: begin seq = mk(K_OPTMP, K_OPLO, K_DUMMY, K_STORE, K_IDLE, K_IDLE); len = 3'd4; end
      default: seq = '0;
    endcase
  end

  logic [3:0] kind;
  logic       last;
  assign kind = seq[{step_q, 2'b00} +: 4];
  assign last = (step_q == len - 3'd1);

  function automatic logic [7:0] rget(input logic [1:0] s, input logic [7:0] a, x, y, sp);
    case (s)
      R_A:     return a;
      R_X:     return x;
      R_Y:     return y;
      default: return sp;
    endcase
  endfunction

  logic [7:0]  idx8, pbyte;
  logic [15:0] eff;
  assign idx8  = isel ? y_q : x_q;
  assign pbyte = lo_q + ((cls == C_INDX) ? x_q : 8'h00) + ((kind == K_PHI) ? 8'h01 : 8'h00);

  always_comb begin
    case (cls)
      C_DP, C_DPDP, C_DPIMM: eff = {8'h00, lo_q};
      C_DPI:                 eff = {8'h00, lo_q + idx8};
      C_ABSI:                eff = {hi_q, lo_q} + {8'h00, idx8};
      C_INDX:                eff = {phi_q, plo_q};
      C_INDY:                eff = {phi_q, plo_q} + {8'h00, y_q};
      C_XIND, C_XINC:        eff = {8'h00, x_q};
      default:               eff = {hi_q, lo_q};
    endcase
  end

  logic fetch_k, ptr_k;
  assign fetch_k = (kind == K_IMM) || (kind == K_OPLO) || (kind == K_OPHI) || (kind == K_OPTMP);
  assign ptr_k   = (kind == K_PLO) || (kind == K_PHI);

  assign mem_rd    = busy_q && (fetch_k || ptr_k || kind == K_SRC || kind == K_LOAD || kind == K_DUMMY);
  assign mem_wr    = busy_q && (kind == K_STORE);
  assign mem_addr  = !busy_q ? 16'h0000 : fetch_k ? pc_q : ptr_k ? {8'h00, pbyte} : eff;
  assign mem_wdata = !mem_wr ? 8'h00 :
                     (cls == C_DPDP || cls == C_DPIMM) ? tmp_q : rget(rsel, a_q, x_q, y_q, sp_q);

  logic       wen;
  logic [7:0] wval;
  assign wen  = busy_q && (kind == K_IMM || kind == K_LOAD || kind == K_XFER);
  assign wval = (kind == K_XFER) ? rget(ssel, a_q, x_q, y_q, sp_q) : mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; op_q <= 8'h00; step_q <= 3'd0; pc_q <= 16'h0000;
      lo_q <= 8'h00; hi_q <= 8'h00; plo_q <= 8'h00; phi_q <= 8'h00; tmp_q <= 8'h00;
      a_q <= 8'h00; x_q <= 8'h00; y_q <= 8'h00; sp_q <= 8'h00; n_q <= 1'b0; z_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          op_q   <= opcode;
          pc_q   <= op_pc;
          step_q <= 3'd0;
        end
      end else begin
        case (kind)
          K_OPLO:         lo_q  <= mem_rdata;
          K_OPHI:         hi_q  <= mem_rdata;
          K_OPTMP, K_SRC: tmp_q <= mem_rdata;
          K_PLO:          plo_q <= mem_rdata;
          K_PHI:          phi_q <= mem_rdata;
          default: ;
        endcase
        if (fetch_k) pc_q <= pc_q + 16'h0001;
        if (wen) begin
          case (rsel)
            R_A:     a_q  <= wval;
            R_X:     x_q  <= wval;
            R_Y:     y_q  <= wval;
            default: sp_q <= wval;
          endcase
          if (rsel != R_SP) begin
            n_q <= wval[7];
            z_q <= (wval == 8'h00);
          end
        end
        if (last && cls == C_XINC) x_q <= x_q + 8'h01;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= 3'd0;
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign next_pc = pc_q;
  assign reg_a   = a_q;
  assign reg_x   = x_q;
  assign reg_y   = y_q;
  assign reg_sp  = sp_q;
  assign flag_n  = n_q;
  assign flag_z  = z_q;

  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_quiet_bus_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_dummy_before_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cls != C_XINC && cls != C_DPDP) |-> ($past(mem_rd) && $past(mem_addr) == mem_addr));
  assert_sp_keeps_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind == K_XFER && rsel == R_SP) |=> $stable({flag_n, flag_z}));
  assert_pc_only_on_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rd) |=> $stable(next_pc));
endmodule

// File: tb/test_movseq.sv
module test_movseq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] op_pc = 16'h0000;
  logic        busy, done, mem_rd, mem_wr, flag_n, flag_z;
  logic [15:0] next_pc, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, reg_a, reg_x, reg_y, reg_sp;

  always #5 clk = ~clk;

  movseq i_movseq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .op_pc(op_pc),
    .busy(busy), .done(done), .next_pc(next_pc), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  logic [7:0] mem [0:4095];
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  ma = 0, mx = 0, my = 0, msp = 0;
  logic        mn = 0, mz = 0;
  logic [15:0] mpc = 0;
  int          en;
  logic [1:0]  ek [0:7];
  logic [15:0] ea [0:7];
  logic [7:0]  ed [0:7];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic e_push(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    ek[en] = k; ea[en] = a; ed[en] = d; en++;
  endtask
  task automatic e_idle; e_push(2'd0, 16'h0, 8'h0); endtask
  task automatic setr(input logic [1:0] r, input logic [7:0] v);
    case (r)
      2'd0: ma = v;
      2'd1: mx = v;
      2'd2: my = v;
      default: msp = v;
    endcase
    if (r != 2'd3) begin mn = v[7]; mz = (v == 8'h00); end
  endtask
  task automatic t_op(output logic [7:0] v);
    e_push(2'd1, mpc, 8'h0); v = mem[mpc[11:0]]; mpc = mpc + 16'd1;
  endtask
  task automatic ld(input logic [1:0] r, input logic [15:0] a);
    e_push(2'd1, a, 8'h0); setr(r, mem[a[11:0]]);
  endtask
  task automatic st(input logic [15:0] a, input logic [7:0] d);
    e_push(2'd1, a, 8'h0); e_push(2'd2, a, d);
  endtask
  task automatic ptr(input logic [7:0] p, output logic [15:0] w);
    logic [7:0] p1, lo, hi;
    p1 = p + 8'd1;
    e_push(2'd1, {8'h00, p}, 8'h0);  lo = mem[{4'h0, p}];
    e_push(2'd1, {8'h00, p1}, 8'h0); hi = mem[{4'h0, p1}];
    w = {hi, lo};
  endtask

  task automatic model(input logic [7:0] op);
    logic [7:0] d, l, h, v;
    logic [15:0] w;
    en = 0;
    case (op)
      8'h7D: begin e_idle; setr(0, mx); end
      8'hDD: begin e_idle; setr(0, my); end
      8'h5D: begin e_idle; setr(1, ma); end
      8'hFD: begin e_idle; setr(2, ma); end
      8'h9D: begin e_idle; setr(1, msp); end
      8'hBD: begin e_idle; msp = mx; end
      8'hE8: begin t_op(v); setr(0, v); end
      8'hCD: begin t_op(v); setr(1, v); end
      8'h8D: begin t_op(v); setr(2, v); end
      8'hE4: begin t_op(d); ld(0, {8'h00, d}); end
      8'hF8: begin t_op(d); ld(1, {8'h00, d}); end
      8'hEB: begin t_op(d); ld(2, {8'h00, d}); end
      8'hF4: begin t_op(d); e_idle; d = d + mx; ld(0, {8'h00, d}); end
      8'hF9: begin t_op(d); e_idle; d = d + my; ld(1, {8'h00, d}); end
      8'hFB: begin t_op(d); e_idle; d = d + mx; ld(2, {8'h00, d}); end
      8'hE5: begin t_op(l); t_op(h); ld(0, {h, l}); end
      8'hE9: begin t_op(l); t_op(h); ld(1, {h, l}); end
      8'hEC: begin t_op(l); t_op(h); ld(2, {h, l}); end
      8'hF5: begin t_op(l); t_op(h); e_idle; ld(0, {h, l} + {8'h00, mx}); end
      8'hF6: begin t_op(l); t_op(h); e_idle; ld(0, {h, l} + {8'h00, my}); end
      8'hE7: begin t_op(d); e_idle; ptr(d + mx, w); ld(0, w); end
      8'hF7: begin t_op(d); e_idle; ptr(d, w); ld(0, w + {8'h00, my}); end
      8'hE6: begin e_idle; ld(0, {8'h00, mx}); end
      8'hBF: begin e_idle; ld(0, {8'h00, mx}); e_idle; mx = mx + 8'd1; end
      8'hC4: begin t_op(d); st({8'h00, d}, ma); end
      8'hD8: begin t_op(d); st({8'h00, d}, mx); end
      8'hCB: begin t_op(d); st({8'h00, d}, my); end
      8'hD4: begin t_op(d); e_idle; d = d + mx; st({8'h00, d}, ma); end
      8'hD9: begin t_op(d); e_idle; d = d + my; st({8'h00, d}, mx); end
      8'hDB: begin t_op(d); e_idle; d = d + mx; st({8'h00, d}, my); end
      8'hC5: begin t_op(l); t_op(h); st({h, l}, ma); end
      8'hC9: begin t_op(l); t_op(h); st({h, l}, mx); end
      8'hCC: begin t_op(l); t_op(h); st({h, l}, my); end
      8'hD5: begin t_op(l); t_op(h); e_idle; st({h, l} + {8'h00, mx}, ma); end
      8'hD6: begin t_op(l); t_op(h); e_idle; st({h, l} + {8'h00, my}, ma); end
      8'hC7: begin t_op(d); e_idle; ptr(d + mx, w); st(w, ma); end
      8'hD7: begin t_op(d); ptr(d, w); e_idle; st(w + {8'h00, my}, ma); end
      8'hC6: begin e_idle; st({8'h00, mx}, ma); end
      8'hAF: begin e_idle; e_idle; e_push(2'd2, {8'h00, mx}, ma); mx = mx + 8'd1; end
      8'hFA: begin t_op(d); e_push(2'd1, {8'h00, d}, 8'h0); v = mem[{4'h0, d}];
                   t_op(d); e_push(2'd2, {8'h00, d}, v); end
      8'h8F: begin t_op(v); t_op(d); st({8'h00, d}, v); end
      default: e_idle;
    endcase
  endtask

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'h7D, 8'hDD, 8'h5D, 8'hFD, 8'h9D, 8'hBD: return "R1";
      8'hE8, 8'hCD, 8'h8D: return "R3";
      8'hE4, 8'hF8, 8'hEB, 8'hC4, 8'hD8, 8'hCB: return "R4";
      8'hF4, 8'hF9, 8'hFB, 8'hD4, 8'hD9, 8'hDB, 8'hF5, 8'hF6, 8'hD5, 8'hD6: return "R5";
      8'hE5, 8'hE9, 8'hEC, 8'hC5, 8'hC9, 8'hCC: return "R6";
      8'hE7, 8'hF7, 8'hC7, 8'hD7: return "R7";
      8'hE6, 8'hBF, 8'hC6, 8'hAF: return "R8";
      8'hFA, 8'h8F: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [7:0] op, input string tag, input bit poke);
    logic [15:0] pc0;
    bit bad;
    pc0 = mpc;
    model(op);
    @(negedge clk);
    opcode = op; op_pc = pc0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < en; i++) begin
      if (poke && i == 1) begin start = 1'b1; opcode = 8'hE8; end
      else start = 1'b0;
      if (!bad && (!busy || mem_rd != (ek[i] == 2'd1) || mem_wr != (ek[i] == 2'd2) ||
          (ek[i] != 2'd0 && mem_addr != ea[i]) || (ek[i] == 2'd2 && mem_wdata != ed[i]))) begin
        bad = 1;
        $display("FAIL %s op=%02h cycle %0d: actual rd=%0b wr=%0b addr=%04h wd=%02h busy=%0b expected kind=%0d addr=%04h wd=%02h",
                 tag, op, i, mem_rd, mem_wr, mem_addr, mem_wdata, busy, ek[i], ea[i], ed[i]);
      end
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (bad) errors++;
    chk(done && !busy, "R10", "done pulse after last bus cycle", {done, busy}, 2'b10);
    chk(!mem_rd && !mem_wr, "R13", "strobes quiet when finished", {mem_rd, mem_wr}, 2'b00);
    chk({reg_a, reg_x, reg_y, reg_sp, flag_n, flag_z, next_pc} == {ma, mx, my, msp, mn, mz, mpc},
        (tag == "R2") ? "R2" : {tag, "/R2"}, "registers a,x,y,sp,n,z,pc",
        {reg_a, reg_x, reg_y, reg_sp, 6'b0, flag_n, flag_z, next_pc},
        {ma, mx, my, msp, 6'b0, mn, mz, mpc});
  endtask

  task automatic prog(input logic [7:0] b0, input logic [7:0] b1);
    mpc = 16'h0900;
    mem[12'h900] = b0;
    mem[12'h901] = b1;
  endtask

  localparam logic [7:0] OPS [42] = '{
    8'h7D, 8'hDD, 8'h5D, 8'hFD, 8'h9D, 8'hBD, 8'hE8, 8'hCD, 8'h8D, 8'hE4, 8'hF8,
    8'hEB, 8'hF4, 8'hF9, 8'hFB, 8'hE5, 8'hE9, 8'hEC, 8'hF5, 8'hF6, 8'hE7, 8'hF7,
    8'hE6, 8'hBF, 8'hC4, 8'hD8, 8'hCB, 8'hD4, 8'hD9, 8'hDB, 8'hC5, 8'hC9, 8'hCC,
    8'hD5, 8'hD6, 8'hC7, 8'hD7, 8'hC6, 8'hAF, 8'hFA, 8'h8F, 8'h00};

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk({reg_a, reg_x, reg_y, reg_sp, flag_n, flag_z, next_pc, busy, done, mem_rd, mem_wr} == '0,
        "R12", "reset state", {reg_a, reg_x, reg_y, reg_sp}, 32'h0);
    rst_n = 1'b1;

    prog(8'h00, 8'h00); run(8'hE8, "R2", 0);
    prog(8'h80, 8'h00); run(8'hE8, "R3", 0);
    prog(8'hF0, 8'h00); run(8'hCD, "R3", 0);
    prog(8'h20, 8'h00); run(8'hF4, "R5", 0);
    prog(8'h05, 8'h00); run(8'h8D, "R3", 0);
    prog(8'hFE, 8'h03); run(8'hF6, "R5", 0);
    mem[12'h0FF] = 8'h34; mem[12'h000] = 8'h02;
    prog(8'h0F, 8'h00); run(8'hE7, "R7", 0);
    run(8'hBD, "R1", 0);
    run(8'h9D, "R1", 0);
    prog(8'hFF, 8'h00); run(8'hCD, "R3", 0);
    run(8'hBF, "R8", 0);
    prog(8'hFF, 8'h00); run(8'hCD, "R3", 0);
    run(8'hAF, "R8", 0);
    run(8'hC6, "R8", 0);
    prog(8'h40, 8'h41); run(8'hFA, "R9", 0);
    prog(8'h5A, 8'h60); run(8'h8F, "R9", 0);
    prog(8'h77, 8'h00); run(8'hC4, "R4", 0);
    prog(8'h00, 8'h00); run(8'h00, "R11", 0);
    prog(8'h10, 8'h00); run(8'hC7, "R10", 1);
    prog(8'hFF, 8'h00); run(8'hD7, "R7", 1);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] op;
      op = OPS[$urandom % 42];
      mpc = 16'h0800 + 16'($urandom % 16'h0700);
      for (int b = 0; b < 3; b++) mem[mpc[11:0] + 12'(b)] = 8'($urandom);
      run(op, req_of(op), (n % 7) == 3);
    end
    finish_up();
  end
endmodule